// File: doc/BRIEF.md
# Adaptive-Threshold QRS Peak Detector

This block takes a stream of 8-bit ECG samples, each marked by a one-cycle valid strobe, and finds the dominant QRS peak of each heartbeat. Every sample is forwarded as a write to an external waveform memory. The write uses a 15-bit address that steps once per sample. The same sample also goes into a private 512-entry circular buffer, and a running 17-bit sum is kept over that buffer.

After reset the detector spends its first 511 samples learning. It then sets its starting threshold halfway between the smallest and largest sample it has seen. From then on it cycles through four phases. First it searches for an onset, which is two consecutive samples above the threshold. On an onset it samples a baseline equal to half the mean of the buffered window. It then looks for a local maximum that is strictly larger than the samples two before and two after it. When it finds one it emits a one-cycle peak pulse with the waveform address of the peak sample, and it re-centres the threshold between the peak and the baseline. Finally it waits for an offset, which is two consecutive samples below the threshold, before it searches for onsets again.

A failed onset test suppresses the next 16 onset tests. A search that finds no maximum within 8 samples is abandoned. Both rules keep noisy data from retriggering the detector.

Top module: `qrs_peak_detect`

## Requirements
- R1: Each cycle with `smp_valid` high drives `wf_we` high in the same cycle, with `wf_data` equal to the sample and `wf_addr` equal to the number of earlier samples modulo 2^15. `wf_addr` changes only after a sample. Samples arrive at least three cycles apart.
- R2: No peak is reported during the first 511 samples after reset. After the 511th sample the threshold becomes floor((min+max)/2) over those 511 samples.
- R3: An onset is recognised only when the current sample and the one before it are both strictly above the threshold. A single sample above the threshold does not count.
- R4: On onset the baseline becomes floor(S/1024). S is the sum of the last 512 samples, including the onset sample. Before the buffer first fills, the unfilled entries count as zero.
- R5: After an onset, each sample x[m] tests the candidate x[m-2]. The candidate is a peak when it is strictly greater than both x[m-4] and x[m]. A peak gives `peak_pulse` high for exactly the one cycle after the sample edge, and `peak_addr` holds the waveform address of x[m-2] until the next peak.
- R6: After a peak, the threshold becomes floor((peak + baseline)/2).
- R7: After a peak no further peak is reported until two consecutive samples are both strictly below the threshold. That event returns the detector to onset search.
- R8: Any sample on which the onset test runs and fails causes the next 16 samples to skip the onset test.
- R9: If 8 samples after an onset produce no peak, the detector returns to onset search with no holdoff.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | One-cycle strobe marking a new sample |
| smp_data | input | 8 | Sample value |
| wf_we | output | 1 | Waveform memory write enable |
| wf_addr | output | 15 | Waveform memory write address |
| wf_data | output | 8 | Waveform memory write data |
| peak_pulse | output | 1 | One-cycle pulse on a detected peak |
| peak_addr | output | 15 | Waveform address of the latest peak sample |

## Verification
The assertions rely on the sample strobe never being high on two adjacent cycles. They also rely on the detector's extra baseline and threshold cycles always falling between samples. The address-lag check assumes no sample lands in the pulse cycle. The stimulus sends one sample every three cycles, so all of these conditions hold throughout. The sample stream covers ramps, wide triangular beats of varying height, narrow spikes, a flat stretch, pseudo-random noise and drifting beats. It runs long enough to wrap the 15-bit address.

// File: rtl/qpd_pkg.sv
package qpd_pkg;
  typedef enum logic [2:0] {
    ST_TRAIN  = 3'd0,
    ST_ONSET  = 3'd1,
    ST_BASE   = 3'd2,
    ST_PEAK   = 3'd3,
    ST_UPD    = 3'd4,
    ST_OFFSET = 3'd5
  } qpd_state_e;
endpackage

// File: rtl/qpd_store.sv
module qpd_store #(
  parameter int DW     = 8,
  parameter int BUF_AW = 9,
  parameter int EXT_AW = 15,
  parameter int SUM_W  = DW + BUF_AW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [DW-1:0]     din,
  output logic [EXT_AW-1:0] ext_ptr,
  output logic [SUM_W-1:0]  win_sum
);
  localparam int DEPTH = 2 ** BUF_AW;

  logic [DW-1:0]     mem [DEPTH];
  logic [BUF_AW-1:0] bptr_q, bptr_d;
  logic [EXT_AW-1:0] eptr_q, eptr_d;
  logic [SUM_W-1:0]  sum_q, sum_d;
  logic              full_q, full_d;
  logic [DW-1:0]     oldest;

  // the entry about to be overwritten leaves the window
  assign oldest = full_q ? mem[bptr_q] : '0;

  always_comb begin
    bptr_d = bptr_q;
    eptr_d = eptr_q;
    sum_d  = sum_q;
    full_d = full_q;
    if (we) begin
      bptr_d = bptr_q + 1'b1;
      eptr_d = eptr_q + 1'b1;
      sum_d  = sum_q + SUM_W'(din) - SUM_W'(oldest);
      if (bptr_q == '1) full_d = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (we) mem[bptr_q] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bptr_q <= '0;
      eptr_q <= '0;
      sum_q  <= '0;
      full_q <= 1'b0;
    end else begin
      bptr_q <= bptr_d;
      eptr_q <= eptr_d;
      sum_q  <= sum_d;
      full_q <= full_d;
    end
  end

  assign ext_ptr = eptr_q;
  assign win_sum = sum_q;
endmodule

// File: rtl/qpd_history.sv
module qpd_history #(
  parameter int DW    = 8,
  parameter int DEPTH = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     en,
  input  logic [DW-1:0]            din,
  output logic [DEPTH-1:0][DW-1:0] taps
);
  logic [DEPTH-1:0][DW-1:0] tap_q;

  for (genvar g = 0; g < DEPTH; g++) begin : g_tap
    if (g == 0) begin : g_head
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  tap_q[0] <= '0;
        else if (en) tap_q[0] <= din;
      end
    end else begin : g_body
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  tap_q[g] <= '0;
        else if (en) tap_q[g] <= tap_q[g-1];
      end
    end
  end

  assign taps = tap_q;
endmodule

// File: rtl/qpd_ctrl.sv
module qpd_ctrl
  import qpd_pkg::*;
#(
  parameter int DW       = 8,
  parameter int BUF_AW   = 9,
  parameter int EXT_AW   = 15,
  parameter int SUM_W    = DW + BUF_AW,
  parameter int HOLD     = 16,
  parameter int PEAK_WIN = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid,
  input  logic [DW-1:0]     x,
  input  logic [DW-1:0]     h1,
  input  logic [DW-1:0]     h2,
  input  logic [DW-1:0]     h4,
  input  logic [SUM_W-1:0]  win_sum,
  input  logic [EXT_AW-1:0] ext_ptr,
  output logic              pulse,
  output logic [EXT_AW-1:0] paddr,
  output logic              training
);
  localparam int HW = $clog2(HOLD + 1);
  localparam int PW = $clog2(PEAK_WIN);
  localparam logic [BUF_AW-1:0] TRAIN_LAST = BUF_AW'(2 ** BUF_AW - 2);
  localparam logic [PW-1:0]     WIN_LAST   = PW'(PEAK_WIN - 1);

  qpd_state_e        st_q, st_d;
  logic [DW-1:0]     thr_q, thr_d, base_q, base_d, pk_q, pk_d;
  logic [DW-1:0]     mn_q, mn_d, mx_q, mx_d;
  logic [HW-1:0]     hold_q, hold_d;
  logic [PW-1:0]     pcnt_q, pcnt_d;
  logic [BUF_AW-1:0] tcnt_q, tcnt_d;
  logic              pulse_q, pulse_d;
  logic [EXT_AW-1:0] paddr_q, paddr_d;

  function automatic logic [DW-1:0] mid(input logic [DW-1:0] a, input logic [DW-1:0] b);
    logic [DW:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[DW:1];
  endfunction

  always_comb begin
    st_d = st_q; thr_d = thr_q; base_d = base_q; pk_d = pk_q;
    mn_d = mn_q; mx_d = mx_q; hold_d = hold_q; pcnt_d = pcnt_q;
    tcnt_d = tcnt_q; pulse_d = 1'b0; paddr_d = paddr_q;
    unique case (st_q)
      ST_TRAIN: if (valid) begin
        if (tcnt_q == '0) begin
          mn_d = x;
          mx_d = x;
        end else begin
          if (x < mn_q) mn_d = x;
          if (x > mx_q) mx_d = x;
        end
        tcnt_d = tcnt_q + 1'b1;
        if (tcnt_q == TRAIN_LAST) begin
          thr_d  = mid(mn_d, mx_d);
          hold_d = '0;
          st_d   = ST_ONSET;
        end
      end
      ST_ONSET: if (valid) begin
        if (hold_q != '0)             hold_d = hold_q - 1'b1;
        else if (x > thr_q && h1 > thr_q) st_d = ST_BASE;
        else                          hold_d = HW'(HOLD);
      end
      ST_BASE: begin
        base_d = DW'(win_sum >> (BUF_AW + 1));
        pcnt_d = '0;
        st_d   = ST_PEAK;
      end
      ST_PEAK: if (valid) begin
        if (h2 > h4 && h2 > x) begin
          pulse_d = 1'b1;
          paddr_d = ext_ptr - EXT_AW'(2);
          pk_d    = h2;
          st_d    = ST_UPD;
        end else if (pcnt_q == WIN_LAST) begin
          hold_d = '0;
          st_d   = ST_ONSET;
        end else begin
          pcnt_d = pcnt_q + 1'b1;
        end
      end
      ST_UPD: begin
        thr_d = mid(pk_q, base_q);
        st_d  = ST_OFFSET;
      end
      ST_OFFSET: if (valid && x < thr_q && h1 < thr_q) begin
        hold_d = '0;
        st_d   = ST_ONSET;
      end
      default: st_d = ST_TRAIN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_TRAIN; thr_q <= '0; base_q <= '0; pk_q <= '0;
      mn_q <= '0; mx_q <= '0; hold_q <= '0; pcnt_q <= '0;
      tcnt_q <= '0; pulse_q <= 1'b0; paddr_q <= '0;
    end else begin
      st_q <= st_d; thr_q <= thr_d; base_q <= base_d; pk_q <= pk_d;
      mn_q <= mn_d; mx_q <= mx_d; hold_q <= hold_d; pcnt_q <= pcnt_d;
      tcnt_q <= tcnt_d; pulse_q <= pulse_d; paddr_q <= paddr_d;
    end
  end

  assign pulse    = pulse_q;
  assign paddr    = paddr_q;
  assign training = (st_q == ST_TRAIN);
endmodule

// File: rtl/qrs_peak_detect.sv
module qrs_peak_detect #(
  parameter int DW       = 8,
  parameter int BUF_AW   = 9,
  parameter int EXT_AW   = 15,
  parameter int HOLD     = 16,
  parameter int PEAK_WIN = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_valid,
  input  logic [DW-1:0]     smp_data,
  output logic              wf_we,
  output logic [EXT_AW-1:0] wf_addr,
  output logic [DW-1:0]     wf_data,
  output logic              peak_pulse,
  output logic [EXT_AW-1:0] peak_addr
);
  localparam int SUM_W = DW + BUF_AW;
  localparam int TAPS  = 4;

  logic [1:0]                rs_q;
  logic                      rst_int_n;
  logic [EXT_AW-1:0]         ext_ptr;
  logic [SUM_W-1:0]          win_sum;
  logic [TAPS-1:0][DW-1:0]   taps;
  logic                      train_active;

  // reset asserts at once, releases on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_int_n = rs_q[1];

  qpd_store #(.DW(DW), .BUF_AW(BUF_AW), .EXT_AW(EXT_AW), .SUM_W(SUM_W)) u_store (
    .clk(clk), .rst_n(rst_int_n), .we(smp_valid), .din(smp_data),
    .ext_ptr(ext_ptr), .win_sum(win_sum)
  );

  qpd_history #(.DW(DW), .DEPTH(TAPS)) u_hist (
    .clk(clk), .rst_n(rst_int_n), .en(smp_valid), .din(smp_data), .taps(taps)
  );

  qpd_ctrl #(.DW(DW), .BUF_AW(BUF_AW), .EXT_AW(EXT_AW), .SUM_W(SUM_W),
             .HOLD(HOLD), .PEAK_WIN(PEAK_WIN)) u_ctrl (
    .clk(clk), .rst_n(rst_int_n), .valid(smp_valid), .x(smp_data),
    .h1(taps[0]), .h2(taps[1]), .h4(taps[3]),
    .win_sum(win_sum), .ext_ptr(ext_ptr),
    .pulse(peak_pulse), .paddr(peak_addr), .training(train_active)
  );

  assign wf_we   = smp_valid;
  assign wf_addr = ext_ptr;
  assign wf_data = smp_data;
endmodule

// File: rtl/qpd_checker.sv
module qpd_checker #(
  parameter int EXT_AW = 15
) (
  input logic              clk,
  input logic              rst_n,
  input logic              smp_valid,
  input logic [EXT_AW-1:0] wf_addr,
  input logic              peak_pulse,
  input logic [EXT_AW-1:0] peak_addr,
  input logic              training
);
  a_r1_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |=> wf_addr == $past(wf_addr) + 1'b1);

  a_r1_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid |=> $stable(wf_addr));

  a_r1_sample_gap: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |=> !smp_valid);

  a_r2_quiet_training: assert property (@(posedge clk) disable iff (!rst_n)
    training |-> !peak_pulse);

  a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    peak_pulse |=> !peak_pulse);

  a_r5_addr_lag: assert property (@(posedge clk) disable iff (!rst_n)
    peak_pulse |-> peak_addr == wf_addr - EXT_AW'(3));

  a_r5_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
    !peak_pulse |-> $stable(peak_addr));
endmodule

bind qrs_peak_detect qpd_checker #(.EXT_AW(EXT_AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .wf_addr(wf_addr),
  .peak_pulse(peak_pulse), .peak_addr(peak_addr), .training(train_active)
);

// File: tb/sim_qrs_peak_detect.sv
module sim_qrs_peak_detect;
  localparam int NSMP = 33000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        smp_valid;
  logic [7:0]  smp_data;
  logic        wf_we;
  logic [14:0] wf_addr;
  logic [7:0]  wf_data;
  logic        peak_pulse;
  logic [14:0] peak_addr;

  int checks = 0;
  int fails  = 0;
  int peaks_seen = 0;

  always #10 clk = ~clk;

  qrs_peak_detect u0 (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
    .wf_we(wf_we), .wf_addr(wf_addr), .wf_data(wf_data),
    .peak_pulse(peak_pulse), .peak_addr(peak_addr)
  );

  // reference state, computed from the requirements at sample level
  int m_buf [512];
  int m_ptr, m_full, m_sum, m_ext;
  int m_h1, m_h2, m_h3, m_h4;
  int m_st, m_thr, m_base, m_hold, m_pcnt, m_tcnt, m_mn, m_mx;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int gen(input int k);
    int j, p, t;
    if (k < 511) return 20 + (k * 37) % 180;
    if (k < 4511) begin
      j = k - 511; p = j % 40; t = (p < 20) ? p : 40 - p;
      return 40 + t * (6 + (j / 40) % 4);
    end
    if (k < 8511) begin
      j = k - 4511; p = j % 25;
      return (p == 10) ? 200 : ((p == 9 || p == 11) ? 130 : 50);
    end
    if (k < 10511) return 60;
    if (k < 18511) begin
      j = k - 10511;
      return ((j * 73 + (j >> 3) * 151) ^ (j * 29)) & 255;
    end
    j = k - 18511; p = j % 31; t = (p < 15) ? p : 30 - p;
    return 30 + (j / 200) % 40 + t * 10;
  endfunction

  // states: 0 learning, 1 onset search, 2 peak search, 3 offset wait
  task automatic mdl_step(input int x, output bit pk, output int paddr, output string tag);
    int old;
    pk = 1'b0; paddr = 0; tag = "R5";
    old = m_full ? m_buf[m_ptr] : 0;
    m_sum = m_sum + x - old;
    m_buf[m_ptr] = x;
    if (m_ptr == 511) m_full = 1;
    m_ptr = (m_ptr + 1) % 512;
    case (m_st)
      0: begin
        tag = "R2";
        if (m_tcnt == 0) begin m_mn = x; m_mx = x; end
        else begin if (x < m_mn) m_mn = x; if (x > m_mx) m_mx = x; end
        m_tcnt++;
        if (m_tcnt == 511) begin m_thr = (m_mn + m_mx) / 2; m_st = 1; m_hold = 0; end
      end
      1: begin
        if (m_hold > 0) begin tag = "R8"; m_hold--; end
        else if (x > m_thr && m_h1 > m_thr) begin
          tag = "R3"; m_base = m_sum / 1024; m_st = 2; m_pcnt = 0;
        end else begin tag = "R3 R8"; m_hold = 16; end
      end
      2: begin
        if (m_h2 > m_h4 && m_h2 > x) begin
          tag = "R4 R5"; pk = 1'b1; paddr = (m_ext - 2) & 32'h7fff;
          m_thr = (m_h2 + m_base) / 2; m_st = 3;
        end else begin
          tag = "R5 R9"; m_pcnt++;
          if (m_pcnt == 8) begin m_st = 1; m_hold = 0; end
        end
      end
      default: begin
        tag = "R6 R7";
        if (x < m_thr && m_h1 < m_thr) begin m_st = 1; m_hold = 0; end
      end
    endcase
    m_h4 = m_h3; m_h3 = m_h2; m_h2 = m_h1; m_h1 = x;
    m_ext = (m_ext + 1) & 32'h7fff;
  endtask

  task automatic send(input int x);
    bit    pk;
    int    pa;
    string tag;
    @(negedge clk);
    smp_valid = 1'b1;
    smp_data  = 8'(x);
    #1;
    chk("R1 we", int'(wf_we), 1);
    chk("R1 addr", int'(wf_addr), m_ext);
    chk("R1 data", int'(wf_data), x);
    mdl_step(x, pk, pa, tag);
    @(negedge clk);
    smp_valid = 1'b0;
    #1;
    chk(tag, int'(peak_pulse), int'(pk));
    if (pk) begin
      peaks_seen++;
      chk("R5 peak_addr", int'(peak_addr), pa);
    end
    @(negedge clk);
  endtask

  task automatic run_all();
    rst_n = 1'b0;
    smp_valid = 1'b0;
    smp_data = '0;
    m_ptr = 0; m_full = 0; m_sum = 0; m_ext = 0;
    m_h1 = 0; m_h2 = 0; m_h3 = 0; m_h4 = 0;
    m_st = 0; m_thr = 0; m_base = 0; m_hold = 0; m_pcnt = 0; m_tcnt = 0; m_mn = 0; m_mx = 0;
    repeat (3) @(negedge clk);
    chk("R5 reset pulse", int'(peak_pulse), 0);
    chk("R5 reset peak_addr", int'(peak_addr), 0);
    chk("R1 reset addr", int'(wf_addr), 0);
    chk("R1 reset we", int'(wf_we), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    for (int k = 0; k < NSMP; k++) send(gen(k));
    // R1: address wrapped past 2^15 samples
    chk("R1 wrap addr", int'(wf_addr), NSMP % 32768);
    // R5: the sweep must have produced detections
    checks++;
    if (peaks_seen == 0) begin
      fails++;
      $display("FAIL R5 peaks actual=0 expected>0");
    end
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (190000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    disable fork;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule